// File: doc/BRIEF.md
# Two-Wire Bus Controller Configuration and Enable Sequencer

This block holds the setup of a two-wire serial bus controller and runs the enable, disable and soft-reset handshakes with the bus engine that sits next to it. Software reaches it through a small word-addressed register port with a one-cycle write strobe and a combinational read path. The block drives the stored setup and an enable level to the engine. The engine answers each enable or disable request with a one-cycle acknowledge.

The setup fields are:
- the operating mode
- a clock-stretch time-out enable
- an idle-bus time-out
- a data hold time
- an automatic-acknowledge (smart) enable
- an address-match mode
- a slave address and its mask
- the baud divisor

The mode, time-out, hold, smart, match and address fields are locked while the controller runs or is starting up. A write to them made while the controller is shutting down is parked in a single slot and lands once the shutdown is confirmed. The baud divisor and the debug word can be written at any time. A soft reset clears every register except the debug word.

Top module: `twi_cfg_ctrl`

## Requirements
- R1: After the asynchronous reset, every register reads zero, STATUS reads zero and `eng_en_o` is low.
- R2: CTRL[4:2] is the mode field. Code 4 selects master operation (`master_o` high) and code 5 selects slave operation (`slave_o` high). Any other code raises neither output.
- R3: The enable state is reported in STATUS[2:1] as 0 off, 1 enabling, 2 on, 3 disabling. Writing CTRL[1]=1 while off moves to enabling and raises `eng_en_o`. `eng_en_ack_i` moves enabling to on. Writing CTRL[1]=0 while on moves to disabling and drops `eng_en_o`. `eng_dis_ack_i` moves disabling to off.
- R4: STATUS[0] is high while enabling, while disabling and during the soft-reset cycle. A write to CTRL[1] made while enabling or disabling is ignored. An acknowledge that does not match the current state is ignored.
- R5: While enabling or on, writes to the protected fields are discarded. The protected fields are CTRL[12:2] (mode [4:2], stretch time-out enable [5], idle time-out [7:6], hold [9:8], smart [10], match mode [12:11]) and the whole ADDR register (address [9:0], mask [25:16]).
- R6: While disabling, a write to a protected register is parked in one slot, and a later write replaces the earlier one. STATUS[3] is high while the slot holds a write. The parked write takes effect on the clock edge after the one that samples `eng_dis_ack_i`. Until then, the register reads its old value.
- R7: BAUD[15:0] (offset 2) and DBG[0] (offset 3) accept writes in every enable state.
- R8: Writing CTRL[0]=1 sets the reset bit and STATUS[0] for one cycle. After that cycle, every register is cleared except DBG, the parked write is dropped and the state is off. In the same write, the reset bit takes priority over CTRL[1].
- R9: The register offsets are 0 CTRL, 1 ADDR, 2 BAUD, 3 DBG and 4 STATUS. Any other offset reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word offset for reads and writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| eng_en_ack_i | input | 1 | Engine confirms that enabling is complete |
| eng_dis_ack_i | input | 1 | Engine confirms that disabling is complete |
| eng_en_o | output | 1 | Enable level to the engine |
| mode_o | output | 3 | Operating mode code |
| master_o | output | 1 | Mode is master |
| slave_o | output | 1 | Mode is slave |
| lowto_en_o | output | 1 | Clock-stretch time-out enable |
| inact_to_o | output | 2 | Idle-bus time-out selection |
| hold_o | output | 2 | Data hold time selection |
| smart_en_o | output | 1 | Automatic acknowledge enable |
| amode_o | output | 2 | Address-match mode |
| saddr_o | output | 10 | Slave address |
| smask_o | output | 10 | Slave address mask |
| baud_o | output | 16 | Baud divisor |
| dbg_o | output | 1 | Debug control bit |

## Verification
The bench writes protected fields during start-up and while running. A design that gated only on the running state would let the start-up write through. It parks two address writes during shutdown and reads STATUS on the very cycle after the disable acknowledge. A design that committed early, or kept the first write instead of the last, shows a cleared pending flag or the wrong address. It also sends acknowledges in the wrong state, issues a soft reset both from the running state and together with the enable bit, and checks that the debug bit survives while the baud divisor clears.

// File: rtl/twi_cfg_pkg.sv
package twi_cfg_pkg;
  typedef enum logic [1:0] {
    PH_OFF       = 2'd0,
    PH_ENABLING  = 2'd1,
    PH_ON        = 2'd2,
    PH_DISABLING = 2'd3
  } en_phase_e;

  localparam int unsigned REG_CTRL = 0;
  localparam int unsigned REG_ADDR = 1;
  localparam int unsigned REG_BAUD = 2;
  localparam int unsigned REG_DBG  = 3;
  localparam int unsigned REG_STAT = 4;

  localparam int unsigned CTRL_SWRST_BIT = 0;
  localparam int unsigned CTRL_EN_BIT    = 1;
  localparam int unsigned ADDR_MASK_LSB  = 16;

  localparam logic [2:0] MODE_MASTER = 3'd4;
  localparam logic [2:0] MODE_SLAVE  = 3'd5;
endpackage

// File: rtl/twi_cfg_enseq.sv
module twi_cfg_enseq
  import twi_cfg_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      ctrl_wr_i,
  input  logic      swrst_req_i,
  input  logic      en_req_i,
  input  logic      en_ack_i,
  input  logic      dis_ack_i,
  output en_phase_e phase_o,
  output logic      swrst_o,
  output logic      en_o,
  output logic      busy_o
);
  en_phase_e phase_q;
  logic      swrst_q;
  logic      rst_go;

  assign rst_go = ctrl_wr_i && swrst_req_i && !swrst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_OFF;
      swrst_q <= 1'b0;
    end else if (swrst_q) begin
      phase_q <= PH_OFF;
      swrst_q <= 1'b0;
    end else if (rst_go) begin
      swrst_q <= 1'b1;  // reset wins over enable bit in the same write
    end else begin
      unique case (phase_q)
        PH_OFF:       if (ctrl_wr_i && en_req_i)  phase_q <= PH_ENABLING;
        PH_ENABLING:  if (en_ack_i)               phase_q <= PH_ON;
        PH_ON:        if (ctrl_wr_i && !en_req_i) phase_q <= PH_DISABLING;
        PH_DISABLING: if (dis_ack_i)              phase_q <= PH_OFF;
        default:                                  phase_q <= PH_OFF;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign swrst_o = swrst_q;
  assign en_o    = (phase_q == PH_ENABLING) || (phase_q == PH_ON);
  assign busy_o  = swrst_q || (phase_q == PH_ENABLING) || (phase_q == PH_DISABLING);

  assert_en_ack_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_ENABLING && en_ack_i && !swrst_q && !rst_go) |=> (phase_q == PH_ON));

  assert_dis_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_DISABLING) |=> (phase_q == PH_DISABLING || phase_q == PH_OFF));

  assert_swrst_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swrst_q |=> (!swrst_q && phase_q == PH_OFF));

  assert_busy_block_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_ENABLING && !en_ack_i && !swrst_q && !rst_go) |=> (phase_q == PH_ENABLING));
endmodule

// File: rtl/twi_cfg_defer.sv
module twi_cfg_defer #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              cap_i,
  input  logic [ADDR_W-1:0] cap_addr_i,
  input  logic [DATA_W-1:0] cap_data_i,
  input  logic              commit_en_i,
  output logic              valid_o,
  output logic              commit_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  logic              valid_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else if (clr_i) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else if (cap_i) begin
      valid_q <= 1'b1;  // newest write replaces the parked one
      addr_q  <= cap_addr_i;
      data_q  <= cap_data_i;
    end else if (commit_o) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o  = valid_q;
  assign commit_o = valid_q && commit_en_i;
  assign addr_o   = addr_q;
  assign data_o   = data_q;

  assert_park_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !commit_en_i && !clr_i && !cap_i) |=> (valid_q && $stable(addr_q) && $stable(data_q)));

  assert_park_take_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && !clr_i) |=> (valid_q && data_q == $past(cap_data_i)));
endmodule

// File: rtl/twi_cfg_regs.sv
module twi_cfg_regs
  import twi_cfg_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned MODE_W  = 3,
  parameter int unsigned INACT_W = 2,
  parameter int unsigned HOLD_W  = 2,
  parameter int unsigned AMODE_W = 2,
  parameter int unsigned SADDR_W = 10,
  parameter int unsigned BAUD_W  = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               lock_i,
  input  logic               prot_wr_i,
  input  logic               unp_wr_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic               cmt_i,
  input  logic [ADDR_W-1:0]  cmt_addr_i,
  input  logic [DATA_W-1:0]  cmt_data_i,
  input  logic               en_bit_i,
  input  logic               swrst_bit_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [MODE_W-1:0]  mode_o,
  output logic               lowto_en_o,
  output logic [INACT_W-1:0] inact_to_o,
  output logic [HOLD_W-1:0]  hold_o,
  output logic               smart_en_o,
  output logic [AMODE_W-1:0] amode_o,
  output logic [SADDR_W-1:0] saddr_o,
  output logic [SADDR_W-1:0] smask_o,
  output logic [BAUD_W-1:0]  baud_o,
  output logic               dbg_o
);
  localparam int unsigned MODE_LSB  = 2;
  localparam int unsigned LOWTO_BIT = MODE_LSB + MODE_W;
  localparam int unsigned INACT_LSB = LOWTO_BIT + 1;
  localparam int unsigned HOLD_LSB  = INACT_LSB + INACT_W;
  localparam int unsigned SMART_BIT = HOLD_LSB + HOLD_W;
  localparam int unsigned AMODE_LSB = SMART_BIT + 1;
  localparam int unsigned CTRL_TOP  = AMODE_LSB + AMODE_W - 1;
  localparam int unsigned CF_W      = CTRL_TOP - MODE_LSB + 1;
  localparam int unsigned PROT_W    = CF_W + 2 * SADDR_W;

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(REG_CTRL);
  localparam logic [ADDR_W-1:0] A_ADDR = ADDR_W'(REG_ADDR);
  localparam logic [ADDR_W-1:0] A_BAUD = ADDR_W'(REG_BAUD);
  localparam logic [ADDR_W-1:0] A_DBG  = ADDR_W'(REG_DBG);

  // protected state packed as {mask, address, ctrl fields}
  logic [PROT_W-1:0] prot_q, prot_n;
  logic [BAUD_W-1:0] baud_q;
  logic              dbg_q;

  function automatic logic [PROT_W-1:0] apply_wr(
    input logic [PROT_W-1:0] cur,
    input logic [ADDR_W-1:0] a,
    input logic [DATA_W-1:0] d
  );
    logic [PROT_W-1:0] r;
    r = cur;
    if (a == A_CTRL) r[CF_W-1:0] = d[CTRL_TOP:MODE_LSB];
    if (a == A_ADDR) begin
      r[CF_W +: SADDR_W]           = d[SADDR_W-1:0];
      r[CF_W + SADDR_W +: SADDR_W] = d[ADDR_MASK_LSB +: SADDR_W];
    end
    return r;
  endfunction

  always_comb begin
    prot_n = prot_q;
    if (cmt_i)     prot_n = apply_wr(prot_n, cmt_addr_i, cmt_data_i);
    if (prot_wr_i) prot_n = apply_wr(prot_n, wr_addr_i, wr_data_i);  // direct write wins
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prot_q <= '0;
      baud_q <= '0;
    end else if (clr_i) begin
      prot_q <= '0;
      baud_q <= '0;
    end else begin
      prot_q <= prot_n;
      if (unp_wr_i && wr_addr_i == A_BAUD) baud_q <= wr_data_i[BAUD_W-1:0];
    end
  end

  // debug word survives soft reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                dbg_q <= 1'b0;
    else if (unp_wr_i && wr_addr_i == A_DBG)    dbg_q <= wr_data_i[0];
  end

  assign mode_o     = prot_q[0 +: MODE_W];
  assign lowto_en_o = prot_q[LOWTO_BIT - MODE_LSB];
  assign inact_to_o = prot_q[INACT_LSB - MODE_LSB +: INACT_W];
  assign hold_o     = prot_q[HOLD_LSB - MODE_LSB +: HOLD_W];
  assign smart_en_o = prot_q[SMART_BIT - MODE_LSB];
  assign amode_o    = prot_q[AMODE_LSB - MODE_LSB +: AMODE_W];
  assign saddr_o    = prot_q[CF_W +: SADDR_W];
  assign smask_o    = prot_q[CF_W + SADDR_W +: SADDR_W];
  assign baud_o     = baud_q;
  assign dbg_o      = dbg_q;

  always_comb begin
    rdata_o = '0;
    unique case (rd_addr_i)
      A_CTRL: begin
        rdata_o[CTRL_TOP:MODE_LSB] = prot_q[CF_W-1:0];
        rdata_o[CTRL_EN_BIT]       = en_bit_i;
        rdata_o[CTRL_SWRST_BIT]    = swrst_bit_i;
      end
      A_ADDR: begin
        rdata_o[SADDR_W-1:0]               = saddr_o;
        rdata_o[ADDR_MASK_LSB +: SADDR_W]  = smask_o;
      end
      A_BAUD:  rdata_o[BAUD_W-1:0] = baud_q;
      A_DBG:   rdata_o[0]          = dbg_q;
      default: rdata_o             = '0;
    endcase
  end

  assert_locked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_i && !clr_i) |=> $stable(prot_q));

  assert_baud_any_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unp_wr_i && wr_addr_i == A_BAUD && !clr_i) |=> (baud_q == $past(wr_data_i[BAUD_W-1:0])));

  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (prot_q == '0 && baud_q == '0 && $stable(dbg_q)));
endmodule

// File: rtl/twi_cfg_ctrl.sv
module twi_cfg_ctrl
  import twi_cfg_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned MODE_W  = 3,
  parameter int unsigned INACT_W = 2,
  parameter int unsigned HOLD_W  = 2,
  parameter int unsigned AMODE_W = 2,
  parameter int unsigned SADDR_W = 10,
  parameter int unsigned BAUD_W  = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic               eng_en_ack_i,
  input  logic               eng_dis_ack_i,
  output logic               eng_en_o,
  output logic [MODE_W-1:0]  mode_o,
  output logic               master_o,
  output logic               slave_o,
  output logic               lowto_en_o,
  output logic [INACT_W-1:0] inact_to_o,
  output logic [HOLD_W-1:0]  hold_o,
  output logic               smart_en_o,
  output logic [AMODE_W-1:0] amode_o,
  output logic [SADDR_W-1:0] saddr_o,
  output logic [SADDR_W-1:0] smask_o,
  output logic [BAUD_W-1:0]  baud_o,
  output logic               dbg_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(REG_CTRL);
  localparam logic [ADDR_W-1:0] A_ADDR = ADDR_W'(REG_ADDR);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_STAT);

  en_phase_e         phase;
  logic              swrst_q, en_lvl, busy;
  logic              live, is_prot, ctrl_wr, rst_wr;
  logic              prot_wr, cap, commit_en, unp_wr;
  logic              pend_valid, pend_commit;
  logic [ADDR_W-1:0] pend_addr;
  logic [DATA_W-1:0] pend_data;
  logic [DATA_W-1:0] reg_rdata;

  assign live      = !swrst_q;  // all writes ignored during the reset cycle
  assign is_prot   = (addr_i == A_CTRL) || (addr_i == A_ADDR);
  assign ctrl_wr   = wr_i && live && (addr_i == A_CTRL);
  assign rst_wr    = ctrl_wr && wdata_i[CTRL_SWRST_BIT];
  assign prot_wr   = wr_i && live && is_prot && !rst_wr && (phase == PH_OFF);
  assign cap       = wr_i && live && is_prot && !rst_wr && (phase == PH_DISABLING);
  assign commit_en = live && (phase == PH_OFF);
  assign unp_wr    = wr_i && live;

  twi_cfg_enseq u_enseq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_wr_i  (ctrl_wr),
    .swrst_req_i(wdata_i[CTRL_SWRST_BIT]),
    .en_req_i   (wdata_i[CTRL_EN_BIT]),
    .en_ack_i   (eng_en_ack_i),
    .dis_ack_i  (eng_dis_ack_i),
    .phase_o    (phase),
    .swrst_o    (swrst_q),
    .en_o       (en_lvl),
    .busy_o     (busy)
  );

  twi_cfg_defer #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_defer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (swrst_q),
    .cap_i      (cap),
    .cap_addr_i (addr_i),
    .cap_data_i (wdata_i),
    .commit_en_i(commit_en),
    .valid_o    (pend_valid),
    .commit_o   (pend_commit),
    .addr_o     (pend_addr),
    .data_o     (pend_data)
  );

  twi_cfg_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MODE_W(MODE_W), .INACT_W(INACT_W),
    .HOLD_W(HOLD_W), .AMODE_W(AMODE_W), .SADDR_W(SADDR_W), .BAUD_W(BAUD_W)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (swrst_q),
    .lock_i     (en_lvl),
    .prot_wr_i  (prot_wr),
    .unp_wr_i   (unp_wr),
    .wr_addr_i  (addr_i),
    .wr_data_i  (wdata_i),
    .cmt_i      (pend_commit),
    .cmt_addr_i (pend_addr),
    .cmt_data_i (pend_data),
    .en_bit_i   (en_lvl),
    .swrst_bit_i(swrst_q),
    .rd_addr_i  (addr_i),
    .rdata_o    (reg_rdata),
    .mode_o     (mode_o),
    .lowto_en_o (lowto_en_o),
    .inact_to_o (inact_to_o),
    .hold_o     (hold_o),
    .smart_en_o (smart_en_o),
    .amode_o    (amode_o),
    .saddr_o    (saddr_o),
    .smask_o    (smask_o),
    .baud_o     (baud_o),
    .dbg_o      (dbg_o)
  );

  always_comb begin
    if (addr_i == A_STAT) begin
      rdata_o    = '0;
      rdata_o[0] = busy;
      rdata_o[2:1] = phase;
      rdata_o[3] = pend_valid;
    end else begin
      rdata_o = reg_rdata;
    end
  end

  assign eng_en_o = en_lvl;
  assign master_o = (mode_o == MODE_W'(MODE_MASTER));
  assign slave_o  = (mode_o == MODE_W'(MODE_SLAVE));

  assert_mode_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(master_o && slave_o));

  assert_commit_after_ack_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_DISABLING && eng_dis_ack_i && pend_valid && live) |=> pend_valid);
endmodule

// File: tb/twi_cfg_ctrl_test.sv
module twi_cfg_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] O_CTRL = 3'd0, O_ADDR = 3'd1, O_BAUD = 3'd2,
                         O_DBG = 3'd3, O_STAT = 3'd4;

  logic        clk, rst_n;
  logic        wr;
  logic [2:0]  addr;
  logic [31:0] wdata, rdata;
  logic        en_ack, dis_ack;
  logic        eng_en, master, slave, lowto, smart, dbg;
  logic [2:0]  mode;
  logic [1:0]  inact, hold, amode;
  logic [9:0]  saddr, smask;
  logic [15:0] baud;

  typedef struct {
    int          kind;   // 0 rdata, 1 eng_en_o, 2 {slave_o,master_o}
    logic [31:0] exp;
    string       tag;
  } sb_item_t;
  sb_item_t sb_q[$];

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  twi_cfg_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .eng_en_ack_i(en_ack), .eng_dis_ack_i(dis_ack),
    .eng_en_o(eng_en), .mode_o(mode), .master_o(master), .slave_o(slave),
    .lowto_en_o(lowto), .inact_to_o(inact), .hold_o(hold), .smart_en_o(smart),
    .amode_o(amode), .saddr_o(saddr), .smask_o(smask), .baud_o(baud), .dbg_o(dbg)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // monitor: compare everything queued this cycle, away from the edge
  always @(negedge clk) begin
    #(CLK_PERIOD/4);
    while (sb_q.size() > 0) begin
      sb_item_t it;
      logic [31:0] act;
      it = sb_q.pop_front();
      case (it.kind)
        0:       act = rdata;
        1:       act = {31'd0, eng_en};
        default: act = {30'd0, slave, master};
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  // each task starts and ends on a falling edge
  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic pulse_en_ack();
    en_ack = 1'b1;
    @(negedge clk);
    en_ack = 1'b0;
  endtask

  task automatic pulse_dis_ack();
    dis_ack = 1'b1;
    @(negedge clk);
    dis_ack = 1'b0;
  endtask

  task automatic expect_item(input int kind, input logic [2:0] a,
                             input logic [31:0] e, input string tag);
    sb_item_t it;
    addr = a;
    it.kind = kind; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr = 1'b0; addr = '0; wdata = '0; en_ack = 1'b0; dis_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    expect_item(0, O_CTRL, 32'h0, "R1 ctrl after reset");
    expect_item(0, O_STAT, 32'h0, "R1 status after reset");
    expect_item(1, O_CTRL, 32'h0, "R1 eng_en after reset");
    expect_item(0, O_BAUD, 32'h0, "R1 baud after reset");

    // R2 master code
    bus_wr(O_CTRL, 32'h10);
    expect_item(2, O_CTRL, 32'h1, "R2 mode 4 is master");
    expect_item(0, O_CTRL, 32'h10, "R2 ctrl readback");

    // R3 enable with slave config in the same write
    bus_wr(O_CTRL, 32'h1DB6);
    expect_item(0, O_STAT, 32'h3, "R3 enabling phase busy");
    expect_item(1, O_CTRL, 32'h1, "R3 eng_en high while enabling");
    expect_item(2, O_CTRL, 32'h2, "R2 mode 5 is slave");

    // R5 locked while enabling; R4 enable bit write ignored while busy
    bus_wr(O_CTRL, 32'h12);
    expect_item(0, O_CTRL, 32'h1DB6, "R5 ctrl write dropped while enabling");
    bus_wr(O_CTRL, 32'h0);
    expect_item(0, O_STAT, 32'h3, "R4 disable write ignored while enabling");
    pulse_dis_ack();
    expect_item(0, O_STAT, 32'h3, "R4 mismatched ack ignored");
    pulse_en_ack();
    expect_item(0, O_STAT, 32'h4, "R3 on after enable ack");

    // R5 locked while on; R7 free fields
    bus_wr(O_ADDR, 32'h00AA_0055);
    expect_item(0, O_ADDR, 32'h0, "R5 addr write dropped while on");
    bus_wr(O_BAUD, 32'h1234);
    expect_item(0, O_BAUD, 32'h1234, "R7 baud written while on");
    bus_wr(O_DBG, 32'h1);
    expect_item(0, O_DBG, 32'h1, "R7 dbg written while on");

    // R3 disable, R6 deferral with replacement
    bus_wr(O_CTRL, 32'h1DB4);
    expect_item(0, O_STAT, 32'h7, "R3 disabling phase busy");
    expect_item(1, O_CTRL, 32'h0, "R3 eng_en low while disabling");
    bus_wr(O_ADDR, 32'h0011_0022);
    bus_wr(O_ADDR, 32'h0033_0044);
    expect_item(0, O_STAT, 32'hF, "R6 pending flag while disabling");
    expect_item(0, O_ADDR, 32'h0, "R6 addr unchanged before ack");
    pulse_dis_ack();
    expect_item(0, O_STAT, 32'h8, "R6 not yet committed on ack cycle");
    expect_item(0, O_ADDR, 32'h0033_0044, "R6 last parked write committed");
    expect_item(0, O_STAT, 32'h0, "R6 pending cleared after commit");

    // R8 soft reset from on
    bus_wr(O_CTRL, 32'h2);
    pulse_en_ack();
    expect_item(0, O_STAT, 32'h4, "R3 on again");
    bus_wr(O_CTRL, 32'h3);
    expect_item(0, O_STAT, 32'h5, "R8 reset cycle busy");
    expect_item(0, O_STAT, 32'h0, "R8 off after reset");
    expect_item(0, O_CTRL, 32'h0, "R8 ctrl cleared");
    expect_item(0, O_BAUD, 32'h0, "R8 baud cleared");
    expect_item(0, O_DBG, 32'h1, "R8 dbg kept");
    expect_item(1, O_CTRL, 32'h0, "R8 eng_en low after reset");

    // R8 priority over enable bit from off
    bus_wr(O_CTRL, 32'h3);
    expect_item(1, O_CTRL, 32'h0, "R8 reset beats enable");
    expect_item(0, O_STAT, 32'h0, "R8 still off after reset with enable");

    // R9 unused offset
    expect_item(0, 3'd5, 32'h0, "R9 unused offset reads zero");

    done = 1;
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule